// File: doc/BRIEF.md
# Uncached Cross-Page Instruction Fetcher

This block fetches a single instruction from a memory region typed as IO, where the bus accepts only halfword-aligned reads and nothing can be cached. A fetch request carries the start PC together with attributes for the page holding that PC and for the page after it. Each page has a 2-bit memory type, an execute permission and a fault kind that says whether a denial is reported as an access fault or as a page fault. The block reads one halfword at the start PC. From that halfword's length bits it decides whether a second halfword is needed and whether that second read lands on the next page. It then joins the halves into a 16-bit or 32-bit instruction.

The result goes out on a valid/ready port. It carries the instruction, a flag for compressed instructions, and exception information: a valid bit, a cause code, a trap value and an exception PC. The exception PC always names the start of the instruction, including when the fault belongs to the second half on the next page. The trap value names the address of the read that failed. A flush input abandons the fetch in progress. A bus response that arrives after a flush is consumed and thrown away.

Top module: `uncFetchUnit`

## Requirements
- R1: A first halfword whose bits [1:0] are not 2'b11 is a complete 16-bit instruction. It is fetched with exactly one bus read at the start PC and delivered zero-extended to 32 bits, with outIsRvc high and no exception.
- R2: A first halfword whose bits [1:0] equal 2'b11 starts a 32-bit instruction. It is fetched with two reads, first at PC and then at PC+2, and delivered as {second halfword, first halfword}.
- R3: Page crossing depends on the instruction length. A 16-bit instruction in the last halfword of a page (PC offset 2^PAGE_BITS-2) needs one read and ignores the next page's attributes. A 32-bit instruction that does not cross also ignores them.
- R4: A request whose start page is not executable produces an exception without any bus read. This holds whatever its memory type. The cause is 12 when curPageFlt is 1 and 1 when it is 0. The trap value and the exception PC both equal the start PC.
- R5: A 32-bit instruction that crosses into a non-executable next page issues only the first read. It reports cause 12 when nxtPageFlt is 1 and 1 when it is 0. The trap value is PC+2, which is the next page base. The exception PC is the start PC.
- R6: A first halfword of 16'h0000 is delivered as an illegal-instruction exception with cause 2, trap value 0 and exception PC equal to the start PC. No second read is made, even at a page end before a non-executable page.
- R7: A bus error response is reported as cause 1. The trap value is the address of the failing read (PC on the first read, PC+2 on the second) and the exception PC is the start PC.
- R8: The memory type is kept as two bits, and only 2'b10 (IO) uses this path. An executable request of type 2'b00, 2'b01 or 2'b11 is accepted and dropped, with no bus read and no output.
- R9: At most one bus read is outstanding at any time. While outValid is high and outReady is low, every output field holds its value.
- R10: Asserting flush aborts the fetch. The aborted request produces no output, and a read response that arrives later is absorbed and never used.
- R11: After reset, reqReady is high while busReqValid and outValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Abort the fetch in progress |
| reqValid | input | 1 | Fetch request valid |
| reqReady | output | 1 | Block can accept a request |
| reqPc | input | PC_W | Start PC (halfword aligned) |
| curMemType | input | 2 | Memory type of the start page (2'b10 = IO) |
| curExec | input | 1 | Start page is executable |
| curPageFlt | input | 1 | Start page denial kind: 1 page fault, 0 access fault |
| nxtExec | input | 1 | Next page is executable |
| nxtPageFlt | input | 1 | Next page denial kind: 1 page fault, 0 access fault |
| busReqValid | output | 1 | Bus read request valid |
| busReqReady | input | 1 | Bus accepts the read |
| busReqAddr | output | PC_W | Halfword-aligned read address |
| busRspValid | input | 1 | Read response valid |
| busRspReady | output | 1 | Block accepts the response |
| busRspData | input | 16 | Halfword read data |
| busRspErr | input | 1 | Read ended in a bus error |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Consumer takes the result |
| outInstr | output | 32 | Instruction, 16-bit forms zero-extended |
| outIsRvc | output | 1 | Instruction is 16-bit |
| outExcValid | output | 1 | Result carries an exception |
| outCause | output | CAUSE_W | Exception cause code |
| outTval | output | PC_W | Trap value |
| outEpc | output | PC_W | Exception PC (instruction start) |

## Verification
If the block loses the first page's PC when the second read fails, the fault shows on outEpc carrying the next page base. That appears on the result beat of the same fetch. A mis-sized memory-type register shows up on the bus: the IO request issues no read, and the fetch ends with no result. A wrong length decision at a page end shows in the read count and in a spurious cause on the next result. A flush that leaves the block waiting on the wrong response puts stale data on the first result after the flush.

// File: rtl/uncFetchPkg.sv
package uncFetchPkg;

  localparam logic [1:0] MEM_TYPE_IO = 2'b10;

  localparam int CAUSE_ACCESS  = 1;
  localparam int CAUSE_ILLEGAL = 2;
  localparam int CAUSE_PAGE    = 12;

  typedef enum logic [2:0] {
    EXC_START_PERM,
    EXC_NEXT_PERM,
    EXC_BUS_FIRST,
    EXC_BUS_SECOND,
    EXC_ILLEGAL
  } excKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic    capReq;
    logic    capLo;
    logic    capHi;
    logic    selHi;
    logic    setExc;
    excKindT excKind;
  } ctrlStrobeT;

  // conditions the datapath reports back to control
  typedef struct packed {
    logic startFault;
    logic isIo;
    logic crosses;
    logic nxtFault;
    logic rspZero;
    logic rspLong;
  } dpStatusT;

endpackage

// File: rtl/uncFetchCtrl.sv
module uncFetchCtrl
  import uncFetchPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       busReqValid,
  input  logic       busReqReady,
  output logic       busRspReady,
  input  logic       busRspValid,
  input  logic       busRspErr,
  output logic       outValid,
  input  logic       outReady,
  input  dpStatusT   stat,
  output ctrlStrobeT strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_REQ1, ST_WAIT1, ST_REQ2, ST_WAIT2, ST_RESP, ST_DRAIN
  } stateT;

  stateT state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt    = state;
    strobe      = '0;
    reqReady    = 1'b0;
    busReqValid = 1'b0;
    busRspReady = 1'b0;
    outValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = !flush;
        if (reqValid && !flush) begin
          strobe.capReq = 1'b1;
          stateNxt      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (flush) begin
          stateNxt = ST_IDLE;
        end else if (stat.startFault) begin
          strobe.setExc  = 1'b1;
          strobe.excKind = EXC_START_PERM;
          stateNxt       = ST_RESP;
        end else if (!stat.isIo) begin
          stateNxt = ST_IDLE;
        end else begin
          stateNxt = ST_REQ1;
        end
      end
      ST_REQ1, ST_REQ2: begin
        busReqValid  = 1'b1;
        strobe.selHi = (state == ST_REQ2);
        if (busReqReady) stateNxt = flush ? ST_DRAIN : ((state == ST_REQ2) ? ST_WAIT2 : ST_WAIT1);
        else if (flush)  stateNxt = ST_IDLE;
      end
      ST_WAIT1: begin
        busRspReady = 1'b1;
        if (flush) begin
          stateNxt = busRspValid ? ST_IDLE : ST_DRAIN;
        end else if (busRspValid) begin
          if (busRspErr) begin
            strobe.setExc  = 1'b1;
            strobe.excKind = EXC_BUS_FIRST;
            stateNxt       = ST_RESP;
          end else begin
            strobe.capLo = 1'b1;
            if (stat.rspZero) begin
              strobe.setExc  = 1'b1;
              strobe.excKind = EXC_ILLEGAL;
              stateNxt       = ST_RESP;
            end else if (!stat.rspLong) begin
              stateNxt = ST_RESP;
            end else if (stat.crosses && stat.nxtFault) begin
              strobe.setExc  = 1'b1;
              strobe.excKind = EXC_NEXT_PERM;
              stateNxt       = ST_RESP;
            end else begin
              stateNxt = ST_REQ2;
            end
          end
        end
      end
      ST_WAIT2: begin
        busRspReady = 1'b1;
        if (flush) begin
          stateNxt = busRspValid ? ST_IDLE : ST_DRAIN;
        end else if (busRspValid) begin
          if (busRspErr) begin
            strobe.setExc  = 1'b1;
            strobe.excKind = EXC_BUS_SECOND;
          end else begin
            strobe.capHi = 1'b1;
          end
          stateNxt = ST_RESP;
        end
      end
      ST_RESP: begin
        outValid = 1'b1;
        if (flush || outReady) stateNxt = ST_IDLE;
      end
      ST_DRAIN: begin
        busRspReady = 1'b1;
        if (busRspValid) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/uncFetchData.sv
module uncFetchData
  import uncFetchPkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int CAUSE_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  output dpStatusT           stat,
  input  logic [PC_W-1:0]    reqPc,
  input  logic [1:0]         curMemType,
  input  logic               curExec,
  input  logic               curPageFlt,
  input  logic               nxtExec,
  input  logic               nxtPageFlt,
  input  logic [15:0]        busRspData,
  output logic [PC_W-1:0]    busReqAddr,
  output logic [31:0]        outInstr,
  output logic               outIsRvc,
  output logic               outExcValid,
  output logic [CAUSE_W-1:0] outCause,
  output logic [PC_W-1:0]    outTval,
  output logic [PC_W-1:0]    outEpc
);

  localparam logic [PC_W-1:0] HALF_STEP = PC_W'(2);

  logic [PC_W-1:0]    pcR;
  logic [1:0]         memTypeR;   // full two bits, IO must not fold into normal
  logic               curExecR, curPageFltR, nxtExecR, nxtPageFltR;
  logic [15:0]        loR, hiR;
  logic               excR;
  logic [CAUSE_W-1:0] causeR, causeNew;
  logic [PC_W-1:0]    tvalR, tvalNew;
  logic [PC_W-1:0]    pcHi;
  logic               longR;

  assign pcHi  = pcR + HALF_STEP;
  assign longR = (loR[1:0] == 2'b11);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR         <= '0;
      memTypeR    <= '0;
      curExecR    <= 1'b0;
      curPageFltR <= 1'b0;
      nxtExecR    <= 1'b0;
      nxtPageFltR <= 1'b0;
      loR         <= '0;
      hiR         <= '0;
      excR        <= 1'b0;
      causeR      <= '0;
      tvalR       <= '0;
    end else begin
      if (strobe.capReq) begin
        pcR         <= {reqPc[PC_W-1:1], 1'b0};
        memTypeR    <= curMemType;
        curExecR    <= curExec;
        curPageFltR <= curPageFlt;
        nxtExecR    <= nxtExec;
        nxtPageFltR <= nxtPageFlt;
        loR         <= '0;
        hiR         <= '0;
        excR        <= 1'b0;
        causeR      <= '0;
        tvalR       <= '0;
      end
      if (strobe.capLo) loR <= busRspData;
      if (strobe.capHi) hiR <= busRspData;
      if (strobe.setExc) begin
        excR   <= 1'b1;
        causeR <= causeNew;
        tvalR  <= tvalNew;
      end
    end
  end

  // cause and trap value; the start PC register is never overwritten
  always_comb begin
    causeNew = CAUSE_W'(CAUSE_ACCESS);
    tvalNew  = pcR;
    unique case (strobe.excKind)
      EXC_START_PERM: causeNew = curPageFltR ? CAUSE_W'(CAUSE_PAGE) : CAUSE_W'(CAUSE_ACCESS);
      EXC_NEXT_PERM: begin
        causeNew = nxtPageFltR ? CAUSE_W'(CAUSE_PAGE) : CAUSE_W'(CAUSE_ACCESS);
        tvalNew  = pcHi;
      end
      EXC_BUS_FIRST:  causeNew = CAUSE_W'(CAUSE_ACCESS);
      EXC_BUS_SECOND: tvalNew  = pcHi;
      EXC_ILLEGAL: begin
        causeNew = CAUSE_W'(CAUSE_ILLEGAL);
        tvalNew  = '0;
      end
      default: ;
    endcase
  end

  assign stat.startFault = !curExecR;
  assign stat.isIo       = (memTypeR == MEM_TYPE_IO);
  assign stat.crosses    = &pcR[PAGE_BITS-1:1];
  assign stat.nxtFault   = !nxtExecR;
  assign stat.rspZero    = (busRspData == 16'h0000);
  assign stat.rspLong    = (busRspData[1:0] == 2'b11);

  assign busReqAddr  = strobe.selHi ? pcHi : pcR;
  assign outInstr    = longR ? {hiR, loR} : {16'h0000, loR};
  assign outIsRvc    = !longR;
  assign outExcValid = excR;
  assign outCause    = causeR;
  assign outTval     = tvalR;
  assign outEpc      = pcR;

endmodule

// File: rtl/uncFetchUnit.sv
module uncFetchUnit
  import uncFetchPkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int CAUSE_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [PC_W-1:0]    reqPc,
  input  logic [1:0]         curMemType,
  input  logic               curExec,
  input  logic               curPageFlt,
  input  logic               nxtExec,
  input  logic               nxtPageFlt,
  output logic               busReqValid,
  input  logic               busReqReady,
  output logic [PC_W-1:0]    busReqAddr,
  input  logic               busRspValid,
  output logic               busRspReady,
  input  logic [15:0]        busRspData,
  input  logic               busRspErr,
  output logic               outValid,
  input  logic               outReady,
  output logic [31:0]        outInstr,
  output logic               outIsRvc,
  output logic               outExcValid,
  output logic [CAUSE_W-1:0] outCause,
  output logic [PC_W-1:0]    outTval,
  output logic [PC_W-1:0]    outEpc
);

  ctrlStrobeT strobe;
  dpStatusT   stat;

  uncFetchCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flush       (flush),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .busReqValid (busReqValid),
    .busReqReady (busReqReady),
    .busRspReady (busRspReady),
    .busRspValid (busRspValid),
    .busRspErr   (busRspErr),
    .outValid    (outValid),
    .outReady    (outReady),
    .stat        (stat),
    .strobe      (strobe)
  );

  uncFetchData #(
    .PC_W      (PC_W),
    .PAGE_BITS (PAGE_BITS),
    .CAUSE_W   (CAUSE_W)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .stat        (stat),
    .reqPc       (reqPc),
    .curMemType  (curMemType),
    .curExec     (curExec),
    .curPageFlt  (curPageFlt),
    .nxtExec     (nxtExec),
    .nxtPageFlt  (nxtPageFlt),
    .busRspData  (busRspData),
    .busReqAddr  (busReqAddr),
    .outInstr    (outInstr),
    .outIsRvc    (outIsRvc),
    .outExcValid (outExcValid),
    .outCause    (outCause),
    .outTval     (outTval),
    .outEpc      (outEpc)
  );

endmodule

// File: rtl/uncFetchChecker.sv
module uncFetchChecker #(
  parameter int PC_W    = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               flush,
  input logic               reqValid,
  input logic               reqReady,
  input logic [PC_W-1:0]    reqPc,
  input logic               busReqValid,
  input logic               busReqReady,
  input logic [PC_W-1:0]    busReqAddr,
  input logic               busRspValid,
  input logic               busRspReady,
  input logic               outValid,
  input logic               outReady,
  input logic [31:0]        outInstr,
  input logic               outIsRvc,
  input logic               outExcValid,
  input logic [CAUSE_W-1:0] outCause,
  input logic [PC_W-1:0]    outTval,
  input logic [PC_W-1:0]    outEpc
);

  logic [1:0]      pendingCnt;
  logic [PC_W-1:0] lastPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingCnt <= '0;
      lastPc     <= '0;
    end else begin
      if (busReqValid && busReqReady)      pendingCnt <= pendingCnt + 2'd1;
      else if (busRspValid && busRspReady) pendingCnt <= pendingCnt - 2'd1;
      if (reqValid && reqReady) lastPc <= {reqPc[PC_W-1:1], 1'b0};
    end
  end

  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> (pendingCnt == 2'd0));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=> (outValid && $stable(outInstr) && $stable(outIsRvc)
      && $stable(outExcValid) && $stable(outCause) && $stable(outTval) && $stable(outEpc)));

  assert_read_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> (busReqAddr == lastPc || busReqAddr == lastPc + PC_W'(2)));

  assert_epc_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outEpc == lastPc));

  assert_illegal_tval_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outExcValid && outCause == CAUSE_W'(2)) |-> (outTval == '0 && outIsRvc));

  assert_rvc_zext_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outExcValid && outIsRvc) |-> (outInstr[31:16] == 16'h0000));

  assert_flush_kill_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !outValid);

endmodule

bind uncFetchUnit uncFetchChecker #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqReady(reqReady),
  .reqPc(reqPc), .busReqValid(busReqValid), .busReqReady(busReqReady),
  .busReqAddr(busReqAddr), .busRspValid(busRspValid), .busRspReady(busRspReady),
  .outValid(outValid), .outReady(outReady), .outInstr(outInstr), .outIsRvc(outIsRvc),
  .outExcValid(outExcValid), .outCause(outCause), .outTval(outTval), .outEpc(outEpc)
);

// File: tb/uncFetchUnit_tb.sv
module uncFetchUnit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 32;
  localparam int CAUSE_W    = 4;
  localparam int NV         = 16;

  typedef struct packed {
    logic [31:0] pc;
    logic [1:0]  ty;
    logic        cx;
    logic        cpf;
    logic        nx;
    logic        npf;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [1:0]  err;   // bit0: first read errors, bit1: second read errors
    logic        xo;
    logic        xe;
    logic [3:0]  xc;
    logic [31:0] xt;
    logic [31:0] xi;
    logic [1:0]  xr;
    logic [3:0]  rq;
  } vecT;

  localparam vecT VECS [NV] = '{
    // R1 16-bit
    '{32'h0000_1000, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 16'h4501, 16'h0000, 2'b00, 1'b1, 1'b0, 4'd0,  32'h0,          32'h0000_4501, 2'd1, 4'd1},
    // R2 32-bit inside a page
    '{32'h0000_1004, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0513, 16'h0010, 2'b00, 1'b1, 1'b0, 4'd0,  32'h0,          32'h0010_0513, 2'd2, 4'd2},
    // R3 16-bit at page end, next page denied
    '{32'h1dfa_dffe, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 16'h4505, 16'h0000, 2'b00, 1'b1, 1'b0, 4'd0,  32'h0,          32'h0000_4505, 2'd1, 4'd3},
    // R2 32-bit across pages, next page allowed
    '{32'h1dfa_dffe, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0093, 16'h0010, 2'b00, 1'b1, 1'b0, 4'd0,  32'h0,          32'h0010_0093, 2'd2, 4'd2},
    // R5 crossing, next page page-fault kind
    '{32'h1dfa_dffe, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0093, 16'h0010, 2'b00, 1'b1, 1'b1, 4'd12, 32'h1dfa_e000, 32'h0,          2'd1, 4'd5},
    // R5 crossing, next page access-fault kind
    '{32'h1dfa_dffe, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0093, 16'h0010, 2'b00, 1'b1, 1'b1, 4'd1,  32'h1dfa_e000, 32'h0,          2'd1, 4'd5},
    // R4 start page denied, access kind
    '{32'h0000_2000, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 16'h4501, 16'h0000, 2'b00, 1'b1, 1'b1, 4'd1,  32'h0000_2000, 32'h0,          2'd0, 4'd4},
    // R4 start page denied, page kind, normal memory type
    '{32'h0000_2000, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 16'h4501, 16'h0000, 2'b00, 1'b1, 1'b1, 4'd12, 32'h0000_2000, 32'h0,          2'd0, 4'd4},
    // R6 zero halfword at page end before denied page
    '{32'h1dfa_dffe, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0010, 2'b00, 1'b1, 1'b1, 4'd2,  32'h0,          32'h0,          2'd1, 4'd6},
    // R7 bus error on first read
    '{32'h0000_3000, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0513, 16'h0010, 2'b01, 1'b1, 1'b1, 4'd1,  32'h0000_3000, 32'h0,          2'd1, 4'd7},
    // R7 bus error on second read across pages
    '{32'h0000_3ffe, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0513, 16'h0010, 2'b10, 1'b1, 1'b1, 4'd1,  32'h0000_4000, 32'h0,          2'd2, 4'd7},
    // R3 32-bit not crossing ignores denied next page
    '{32'h0000_1ffc, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0013, 16'h0000, 2'b00, 1'b1, 1'b0, 4'd0,  32'h0,          32'h0000_0013, 2'd2, 4'd3},
    // R8 non-IO types dropped
    '{32'h0000_5000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 16'h4501, 16'h0000, 2'b00, 1'b0, 1'b0, 4'd0,  32'h0,          32'h0,          2'd0, 4'd8},
    '{32'h0000_5000, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 16'h4501, 16'h0000, 2'b00, 1'b0, 1'b0, 4'd0,  32'h0,          32'h0,          2'd0, 4'd8},
    '{32'h0000_5000, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 16'h4501, 16'h0000, 2'b00, 1'b0, 1'b0, 4'd0,  32'h0,          32'h0,          2'd0, 4'd8},
    // R1 16-bit at page end
    '{32'h0000_5ffe, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 16'h8082, 16'h0000, 2'b00, 1'b1, 1'b0, 4'd0,  32'h0,          32'h0000_8082, 2'd1, 4'd1}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               flush = 1'b0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic [PC_W-1:0]    reqPc = '0;
  logic [1:0]         curMemType = 2'b00;
  logic               curExec = 1'b0;
  logic               curPageFlt = 1'b0;
  logic               nxtExec = 1'b0;
  logic               nxtPageFlt = 1'b0;
  logic               busReqValid;
  logic               busReqReady = 1'b1;
  logic [PC_W-1:0]    busReqAddr;
  logic               busRspValid = 1'b0;
  logic               busRspReady;
  logic [15:0]        busRspData = '0;
  logic               busRspErr = 1'b0;
  logic               outValid;
  logic               outReady = 1'b1;
  logic [31:0]        outInstr;
  logic               outIsRvc;
  logic               outExcValid;
  logic [CAUSE_W-1:0] outCause;
  logic [PC_W-1:0]    outTval;
  logic [PC_W-1:0]    outEpc;

  int nRun  = 0;
  int nFail = 0;

  // memory model state
  logic [31:0] memPc  = '0;
  logic [15:0] memLo  = '0;
  logic [15:0] memHi  = '0;
  logic [1:0]  memErr = '0;
  logic [31:0] heldAddr = '0;
  int          extraLat = 0;
  int          armCnt = 0;
  int          reads = 0;
  logic        rspFire = 1'b0;

  uncFetchUnit u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqReady(reqReady),
    .reqPc(reqPc), .curMemType(curMemType), .curExec(curExec), .curPageFlt(curPageFlt),
    .nxtExec(nxtExec), .nxtPageFlt(nxtPageFlt), .busReqValid(busReqValid),
    .busReqReady(busReqReady), .busReqAddr(busReqAddr), .busRspValid(busRspValid),
    .busRspReady(busRspReady), .busRspData(busRspData), .busRspErr(busRspErr),
    .outValid(outValid), .outReady(outReady), .outInstr(outInstr), .outIsRvc(outIsRvc),
    .outExcValid(outExcValid), .outCause(outCause), .outTval(outTval), .outEpc(outEpc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bus responder, acts on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (rspFire) begin
        busRspValid = 1'b0;
        rspFire     = 1'b0;
      end
      if (armCnt == 1) begin
        busRspValid = 1'b1;
        busRspData  = (heldAddr == memPc) ? memLo : memHi;
        busRspErr   = (heldAddr == memPc) ? memErr[0] : memErr[1];
      end
      if (armCnt > 0) armCnt--;
      if (busRspValid && busRspReady) rspFire = 1'b1;
      if (busReqValid && busReqReady) begin
        heldAddr = busReqAddr;
        armCnt   = 1 + extraLat;
        reads++;
      end
    end
  end

  task automatic chkEq(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic issueReq(input vecT v);
    memPc = v.pc; memLo = v.lo; memHi = v.hi; memErr = v.err;
    reads = 0;
    @(negedge clk);
    reqPc = v.pc; curMemType = v.ty; curExec = v.cx; curPageFlt = v.cpf;
    nxtExec = v.nx; nxtPageFlt = v.npf;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic runVec(input vecT v);
    string rq;
    logic  seen;
    rq = $sformatf("R%0d", v.rq);
    issueReq(v);
    seen = 1'b0;
    for (int i = 0; i < 30 && !seen; i++) begin
      if (outValid) seen = 1'b1;
      else @(negedge clk);
    end
    chkEq(rq, "result produced", 64'(seen), 64'(v.xo));
    if (seen && v.xo) begin
      chkEq(rq, "exception flag", 64'(outExcValid), 64'(v.xe));
      chkEq(rq, "exception pc", 64'(outEpc), 64'(v.pc));
      if (v.xe) begin
        chkEq(rq, "cause", 64'(outCause), 64'(v.xc));
        chkEq(rq, "trap value", 64'(outTval), 64'(v.xt));
      end else begin
        chkEq(rq, "instruction", 64'(outInstr), 64'(v.xi));
      end
    end
    chkEq(rq, "bus reads", 64'(reads), 64'(v.xr));
    if (seen) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    vecT   tmp;
    int    cnt;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chkEq("R11", "reqReady after reset", 64'(reqReady), 64'd1);
    chkEq("R11", "busReqValid after reset", 64'(busReqValid), 64'd0);
    chkEq("R11", "outValid after reset", 64'(outValid), 64'd0);

    for (int k = 0; k < NV; k++) runVec(VECS[k]);

    // R9 backpressure: result held while not taken
    tmp = VECS[1];
    outReady = 1'b0;
    issueReq(tmp);
    cnt = 0;
    while (!outValid && cnt < 30) begin @(negedge clk); cnt++; end
    held = outInstr;
    repeat (3) @(negedge clk);
    chkEq("R9", "valid held", 64'(outValid), 64'd1);
    chkEq("R9", "instruction held", 64'(outInstr), 64'(held));
    chkEq("R9", "held instruction value", 64'(outInstr), 64'h0010_0513);
    // R10 flush while result is pending
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chkEq("R10", "result dropped by flush", 64'(outValid), 64'd0);
    outReady = 1'b1;

    // R10 flush while a slow read is outstanding
    tmp = VECS[0];
    tmp.pc = 32'h0000_6000;
    tmp.lo = 16'h4511;
    extraLat = 3;
    issueReq(tmp);
    cnt = 0;
    while (!busRspReady && cnt < 30) begin @(negedge clk); cnt++; end
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      if (outValid) cnt++;
      @(negedge clk);
    end
    chkEq("R10", "no result after flush", 64'(cnt), 64'd0);
    chkEq("R10", "reads of aborted fetch", 64'(reads), 64'd1);
    extraLat = 0;
    // next fetch sees its own data, not the late response
    tmp.lo = 16'h4519;
    tmp.xi = 32'h0000_4519;
    tmp.rq = 4'd10;
    runVec(tmp);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule